// File: doc/BRIEF.md
# Real-Time Clock Register Front End

This block is the host-facing register file of a real-time clock. A byte-wide request channel reaches a bank of raw time and calendar bytes at the low addresses. Four status and control registers sit directly above that bank. The block holds the oscillator divider code and the periodic-rate code, and it reports an update-in-progress flag. It produces the one-second tick and the periodic interrupt tick that drive the timekeeping counter and the interrupt logic downstream. It also exports the freeze (SET) bit to the time counter.

The request channel uses valid/ready. `req_ready` is held high, so every request with `req_valid` high is accepted on the clock edge where it is presented, and the channel never applies back-pressure. An accepted read returns its byte on `rsp_data` with `rsp_valid` high for exactly one cycle, one cycle after acceptance. The response channel has no ready, so the consumer must take the response in that cycle. Writes produce no response.

The block does not stop on a configuration it cannot honour. Such a write still takes effect, and it also sets a sticky error flag that only reset clears.

Top module: `rtc_reg_if`

## Requirements
- R1: After reset, the status register (address NUM_DATA) holds divider code 3'b010 in bits 6:4, rate code 4'b0110 in bits 3:0 and a clear update flag in bit 7. The control register (address NUM_DATA+1) reads 0x42 when `bin_mode` is 0 and 0x46 when it is 1. `cfg_err` and `freeze` are 0, and every data byte reads 0x00.
- R2: Addresses 0 to NUM_DATA-1 store any written byte and return it on read.
- R3: A write to the status register sets bits 6:0 to the written value and leaves bit 7 (the update flag) unchanged.
- R4: Every read of the status register inverts bit 7 and then returns the register with the inverted bit.
- R5: Addresses NUM_DATA+2 and NUM_DATA+3 always read 0x00. Addresses above them read 0x00, and writes to them change no stored byte.
- R6: While the divider field holds 3'b110 or 3'b111, `sec_tick` stays low.
- R7: When a write to the status register changes the divider field from a disabled code to any other code, the first `sec_tick` comes SEC_CLKS/2 cycles after the write edge. Later ticks follow every SEC_CLKS cycles.
- R8: While the divider runs without being restarted, `sec_tick` pulses for one cycle every SEC_CLKS cycles.
- R9: Control bit 6 is the periodic enable. Setting it from 0 starts `per_tick`, with the first pulse PER_CLKS cycles after the write. Writing it as 1 while it is already 1 keeps the running phase. Clearing it stops `per_tick`.
- R10: A write with an unsupported configuration sets `cfg_err`, and the flag stays set until reset. For the status register this is a divider code other than 3'b010, 3'b110 or 3'b111, or a rate code other than 4'b0110. For the control register this is bit 5 or bit 4 set (alarm or update interrupt), bit 2 set (binary mode), bit 1 clear (12-hour format) or bit 0 set (daylight saving). Any other write leaves `cfg_err` unchanged.
- R11: `freeze` equals control register bit 7.
- R12: `req_ready` is always 1. `rsp_valid` is high exactly in the cycle after an accepted read, and low after writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bin_mode | input | 1 | Reset value of the data-mode bit (0 = BCD) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_data | output | 8 | Read data |
| sec_tick | output | 1 | One-second tick pulse |
| per_tick | output | 1 | Periodic interrupt tick pulse |
| freeze | output | 1 | Halts the downstream time counter |
| cfg_err | output | 1 | Sticky unsupported-configuration flag |

## Verification
On every cycle, the assertions check the response timing and the zero reads of registers C and D. They also check that a status write keeps the update flag, that a status read returns the inverted flag, and that no tick appears while the divider or the periodic enable is off. Checking `freeze` against the last control write and keeping `cfg_err` sticky are assertions too. Only the bench scenarios can show the exact tick spacing: the half-period first tick after re-enabling the divider, the full-period cadence, and the periodic phase kept when the enable is rewritten. Likewise, only sweeps that reset the block between cases can cover the full error decode over every divider and rate code and every control byte.

// File: rtl/rtc_reg_pkg.sv
package rtc_reg_pkg;
  localparam logic [2:0] DV_OSC_32K = 3'b010;
  localparam logic [2:0] DV_HOLD_0  = 3'b110;
  localparam logic [2:0] DV_HOLD_1  = 3'b111;
  localparam logic [3:0] RATE_1KHZ  = 4'b0110;

  // control register bit positions (software decodes these)
  localparam int CB_SET  = 7;
  localparam int CB_PIE  = 6;
  localparam int CB_AIE  = 5;
  localparam int CB_UIE  = 4;
  localparam int CB_DM   = 2;
  localparam int CB_H24  = 1;
  localparam int CB_DSE  = 0;

  function automatic logic dv_is_off(input logic [2:0] dv);
    return (dv == DV_HOLD_0) || (dv == DV_HOLD_1);
  endfunction
endpackage

// File: rtl/rtc_data_bank.sv
module rtc_data_bank #(
  parameter int NUM_DATA = 10,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  logic [7:0] bytes_q [NUM_DATA];

  for (genvar g = 0; g < NUM_DATA; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bytes_q[g] <= 8'h00;
      else if (we && (addr == ADDR_W'(g)))
        bytes_q[g] <= wdata;
    end
  end

  always_comb begin
    rdata = 8'h00;
    for (int i = 0; i < NUM_DATA; i++)
      if (addr == ADDR_W'(i)) rdata = bytes_q[i];
  end
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_reg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bin_mode,
  input  logic       wr_stat,
  input  logic       wr_ctrl,
  input  logic       rd_stat,
  input  logic [7:0] wdata,
  output logic [7:0] stat_q,
  output logic [7:0] ctrl_q,
  output logic       div_run,
  output logic       div_start,
  output logic       pie_start,
  output logic       err_q
);
  logic bad_stat, bad_ctrl;

  always_comb begin
    bad_stat = (!dv_is_off(wdata[6:4]) && (wdata[6:4] != DV_OSC_32K)) ||
               (wdata[3:0] != RATE_1KHZ);
    bad_ctrl = wdata[CB_AIE] || wdata[CB_UIE] || wdata[CB_DM] ||
               !wdata[CB_H24] || wdata[CB_DSE];
  end

  assign div_run   = !dv_is_off(stat_q[6:4]);
  assign div_start = wr_stat && dv_is_off(stat_q[6:4]) && !dv_is_off(wdata[6:4]);
  assign pie_start = wr_ctrl && wdata[CB_PIE] && !ctrl_q[CB_PIE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= {1'b0, DV_OSC_32K, RATE_1KHZ};
      ctrl_q <= 8'h42 | {5'd0, bin_mode, 2'd0};
      err_q  <= 1'b0;
    end else begin
      if (wr_stat)
        stat_q <= {stat_q[7], wdata[6:0]};
      else if (rd_stat)
        stat_q[7] <= ~stat_q[7];
      if (wr_ctrl)
        ctrl_q <= wdata;
      if ((wr_stat && bad_stat) || (wr_ctrl && bad_ctrl))
        err_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
  parameter int PERIOD = 32768,
  parameter int RELOAD = 16384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  logic [CNT_W-1:0] cnt_q;

  assign tick = run && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= CNT_W'(PERIOD - 1);
    else if (restart)
      cnt_q <= CNT_W'(RELOAD - 1);
    else if (run)
      cnt_q <= (cnt_q == '0) ? CNT_W'(PERIOD - 1) : cnt_q - 1'b1;
  end
endmodule

// File: rtl/rtc_reg_if.sv
module rtc_reg_if
  import rtc_reg_pkg::*;
#(
  parameter int NUM_DATA = 10,
  parameter int ADDR_W   = 4,
  parameter int SEC_CLKS = 32768,
  parameter int PER_CLKS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bin_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data,
  output logic              sec_tick,
  output logic              per_tick,
  output logic              freeze,
  output logic              cfg_err
);
  localparam int HALF_CLKS = SEC_CLKS / 2;
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(NUM_DATA);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(NUM_DATA + 1);

  logic       wr_req, rd_req, data_we;
  logic [7:0] data_rd, stat_q, ctrl_q, rd_byte;
  logic       div_run, div_start, pie_start;

  assign req_ready = 1'b1;
  assign wr_req    = req_valid && req_write;
  assign rd_req    = req_valid && !req_write;
  assign data_we   = wr_req && (req_addr < A_STAT);

  rtc_data_bank #(.NUM_DATA(NUM_DATA), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(data_we), .addr(req_addr),
    .wdata(req_wdata), .rdata(data_rd));

  rtc_ctrl_regs u_ctrl (
    .clk(clk), .rst_n(rst_n), .bin_mode(bin_mode),
    .wr_stat(wr_req && (req_addr == A_STAT)),
    .wr_ctrl(wr_req && (req_addr == A_CTRL)),
    .rd_stat(rd_req && (req_addr == A_STAT)),
    .wdata(req_wdata), .stat_q(stat_q), .ctrl_q(ctrl_q),
    .div_run(div_run), .div_start(div_start), .pie_start(pie_start),
    .err_q(cfg_err));

  rtc_tick_gen #(.PERIOD(SEC_CLKS), .RELOAD(HALF_CLKS)) u_sec (
    .clk(clk), .rst_n(rst_n), .run(div_run), .restart(div_start),
    .tick(sec_tick));

  rtc_tick_gen #(.PERIOD(PER_CLKS), .RELOAD(PER_CLKS)) u_per (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q[CB_PIE]), .restart(pie_start),
    .tick(per_tick));

  assign freeze = ctrl_q[CB_SET];

  always_comb begin
    if (req_addr < A_STAT)       rd_byte = data_rd;
    else if (req_addr == A_STAT) rd_byte = {~stat_q[7], stat_q[6:0]};
    else if (req_addr == A_CTRL) rd_byte = ctrl_q;
    else                         rd_byte = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= 8'h00;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_data <= rd_byte;
    end
  end
endmodule

// File: rtl/rtc_reg_if_chk.sv
module rtc_reg_if_chk #(
  parameter int NUM_DATA = 10,
  parameter int ADDR_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [7:0]        req_wdata,
  input logic              rsp_valid,
  input logic [7:0]        rsp_data,
  input logic              sec_tick,
  input logic              per_tick,
  input logic              freeze,
  input logic              cfg_err,
  input logic [7:0]        stat_q,
  input logic [7:0]        ctrl_q
);
  logic rd, wr_stat, rd_stat, wr_ctrl, rd_cd;
  assign rd      = req_valid && !req_write;
  assign rd_stat = rd && (req_addr == ADDR_W'(NUM_DATA));
  assign wr_stat = req_valid && req_write && (req_addr == ADDR_W'(NUM_DATA));
  assign wr_ctrl = req_valid && req_write && (req_addr == ADDR_W'(NUM_DATA + 1));
  assign rd_cd   = rd && ((req_addr == ADDR_W'(NUM_DATA + 2)) ||
                          (req_addr == ADDR_W'(NUM_DATA + 3)));

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid); // R12
  AST_NO_RSP_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rsp_valid); // R12
  AST_CD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cd |=> (rsp_data == 8'h00)); // R5
  AST_UIP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> (stat_q[7] == $past(stat_q[7]))); // R3
  AST_UIP_FLIP_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> (rsp_data[7] == !$past(stat_q[7]))); // R4
  AST_NO_SEC_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[6:5] == 2'b11) |-> !sec_tick); // R6
  AST_NO_PER_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[6] |-> !per_tick); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err); // R10
  AST_FREEZE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (freeze == $past(req_wdata[7]))); // R11
endmodule

bind rtc_reg_if rtc_reg_if_chk #(.NUM_DATA(NUM_DATA), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .rsp_data(rsp_data), .sec_tick(sec_tick), .per_tick(per_tick),
  .freeze(freeze), .cfg_err(cfg_err), .stat_q(stat_q), .ctrl_q(ctrl_q));

// File: tb/test_rtc_reg_if.sv
module test_rtc_reg_if;
  localparam int ND  = 10;
  localparam int AW  = 4;
  localparam int SEC = 20;
  localparam int PER = 6;
  localparam logic [AW-1:0] A_STAT = AW'(ND);
  localparam logic [AW-1:0] A_CTRL = AW'(ND + 1);

  logic clk = 1'b0, rst_n = 1'b0, bin_mode = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid, sec_tick, per_tick, freeze, cfg_err;
  logic [7:0] rsp_data;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtc_reg_if #(.NUM_DATA(ND), .ADDR_W(AW), .SEC_CLKS(SEC), .PER_CLKS(PER)) i_rtc_reg_if (
    .clk(clk), .rst_n(rst_n), .bin_mode(bin_mode), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .sec_tick(sec_tick), .per_tick(per_tick), .freeze(freeze), .cfg_err(cfg_err));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic bm);
    @(negedge clk);
    bin_mode = bm; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 rsp_valid after read", int'(rsp_valid), 1);
    d = rsp_data;
  endtask

  // count negedges after the current one until the tick shows (limit 200)
  task automatic gap_to(input bit per, output int k);
    k = 0;
    do begin
      @(negedge clk); k++;
    end while (!(per ? per_tick : sec_tick) && k < 200);
  endtask

  initial begin
    logic [7:0] v;
    int k;
    // R1 reset state, both data modes
    for (int bm = 0; bm < 2; bm++) begin
      do_reset(bm[0]);
      chk("R1 cfg_err", int'(cfg_err), 0);
      chk("R1 freeze", int'(freeze), 0);
      chk("R12 ready", int'(req_ready), 1);
      rd(A_CTRL, v); chk("R1 ctrl reset", v, bm ? 8'h46 : 8'h42);
      rd(A_STAT, v); chk("R1/R4 stat first read", v, 8'hA6);
      rd(A_STAT, v); chk("R4 stat second read", v, 8'h26);
      for (int a = 0; a < ND; a++) begin
        rd(AW'(a), v); chk("R1 data reset", v, 0);
      end
    end
    // R2 data bytes, several patterns
    for (int p = 0; p < 4; p++) begin
      for (int a = 0; a < ND; a++) wr(AW'(a), 8'((a * 37 + p * 91) ^ (p * 8'h55)));
      chk("R12 no rsp after write", int'(rsp_valid), 0);
      for (int a = 0; a < ND; a++) begin
        rd(AW'(a), v); chk("R2 data readback", v, 8'((a * 37 + p * 91) ^ (p * 8'h55)));
      end
    end
    // R5 C/D and unused addresses
    wr(AW'(ND + 2), 8'h5A); wr(AW'(ND + 3), 8'hA5);
    wr(AW'(ND + 4), 8'hFF); wr(AW'(ND + 5), 8'hFF);
    for (int a = ND + 2; a < (1 << AW); a++) begin
      rd(AW'(a), v); chk("R5 high address reads zero", v, 0);
    end
    for (int a = 0; a < ND; a++) begin
      rd(AW'(a), v); chk("R5 data untouched", v, 8'((a * 37 + 3 * 91) ^ (3 * 8'h55)));
    end
    chk("R10 no error from C/D writes", int'(cfg_err), 0);
    // R3 R10 status sweep over all divider and rate codes
    for (int dv = 0; dv < 8; dv++)
      for (int rs = 0; rs < 16; rs++) begin
        do_reset(1'b0);
        rd(A_STAT, v);                       // flag now 1
        wr(A_STAT, 8'({1'b0, 3'(dv), 4'(rs)}));
        chk("R10 status error decode", int'(cfg_err),
            int'(!(dv == 2 || dv == 6 || dv == 7) || rs != 6));
        rd(A_STAT, v);
        chk("R3 status write keeps flag", v, {1'b0, 3'(dv), 4'(rs)});
      end
    // R10 R11 control sweep
    for (int b = 0; b < 256; b++) begin
      do_reset(1'b0);
      wr(A_CTRL, 8'(b));
      chk("R10 control error decode", int'(cfg_err),
          int'(b[5] || b[4] || b[2] || !b[1] || b[0]));
      chk("R11 freeze", int'(freeze), b[7]);
      rd(A_CTRL, v); chk("R9 control readback", v, b);
    end
    // R10 sticky
    do_reset(1'b0);
    wr(A_CTRL, 8'h40);
    wr(A_CTRL, 8'h42); wr(A_STAT, 8'h26);
    chk("R10 sticky after good writes", int'(cfg_err), 1);
    // R8 cadence from reset
    do_reset(1'b0);
    gap_to(1'b0, k);
    gap_to(1'b0, k); chk("R8 second tick spacing", k, SEC);
    gap_to(1'b0, k); chk("R8 second tick spacing", k, SEC);
    // R6 disabled codes
    for (int c = 6; c < 8; c++) begin
      wr(A_STAT, 8'({1'b0, 3'(c), 4'h6}));
      k = 0;
      for (int i = 0; i < 3 * SEC; i++) begin
        if (sec_tick) k++;
        @(negedge clk);
      end
      chk("R6 no tick while disabled", k, 0);
    end
    // R7 restart timing
    wr(A_STAT, 8'h26);
    k = 1;
    while (!sec_tick && k < 200) begin @(negedge clk); k++; end
    chk("R7 first tick after enable", k, SEC / 2);
    gap_to(1'b0, k); chk("R7 then full period", k, SEC);
    // R9 periodic timer
    do_reset(1'b0);
    gap_to(1'b1, k);
    gap_to(1'b1, k); chk("R9 periodic spacing", k, PER);
    wr(A_CTRL, 8'h02);
    k = 0;
    for (int i = 0; i < 3 * PER; i++) begin
      if (per_tick) k++;
      @(negedge clk);
    end
    chk("R9 stopped when cleared", k, 0);
    wr(A_CTRL, 8'h42);
    k = 1;
    while (!per_tick && k < 200) begin @(negedge clk); k++; end
    chk("R9 first periodic after set", k, PER);
    wr(A_CTRL, 8'h42);                       // rewrite while set: no restart
    k = 1;
    while (!per_tick && k < 200) begin @(negedge clk); k++; end
    chk("R9 phase kept on rewrite", k, PER);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule